// File: doc/BRIEF.md
# Descriptor-Driven Bus Waveform Sequencer

This block is a bus master for a simple external parallel peripheral. Software first loads a small descriptor memory that holds four waveforms. A trigger then starts one of them. Each waveform is a program of eight steps. Steps 0 to 6 are active. Step 7 is the resting step, and reaching it ends the transaction.

In every step the engine reads a four-byte descriptor made of four bytes:
- a length/branch byte,
- a step opcode,
- an output byte that sets the control lines,
- a ready-function byte.

A plain step holds for a programmed number of clocks and then moves to the next step. A decision step lasts one clock. It then jumps to one of two encoded targets, chosen by a logic function of two selected ready terms.

When a step enables data, the engine drives the write word onto the bus in write waveforms, or captures the bus in read waveforms. The two FIFO waveforms also count down a transfer counter. Its "final transfer" term lets a decision step loop on itself until the burst ends. An abort input returns the engine to rest at once, and a done pulse marks the end of each transaction.

Top module: `wave_seq`

## Requirements
- R1: After synchronous reset the engine is at rest: `state_out` is 7, and `busy`, `done`, `bus_oe` and `rd_valid` are 0. All descriptor bytes read as zero.
- R2: A descriptor write with `cfg_we` high stores `cfg_wdata` at address {waveform[1:0], section[1:0], step[2:0]}. The sections are: 0 length/branch, 1 opcode, 2 output, 3 ready function.
- R3: A `go` while at rest starts waveform `go_sel` at step 0 on the next clock and loads `go_count` into the counter. A `go` while busy has no effect on the waveform that is running.
- R4: A step whose opcode bit 0 is clear lasts as many clocks as its length/branch byte, with 0 treated as 1. It then moves to the next step; leaving step 6 reaches step 7.
- R5: A step whose opcode bit 0 is set lasts one clock. It then goes to length/branch bits [5:3] when the ready function is true, and to bits [2:0] when it is false.
- R6: In the ready-function byte, bits [5:3] select term A and bits [2:0] select term B. Bits [7:6] pick the function: 0 is A AND B, 1 is A OR B, 2 is A XOR B, 3 is A AND NOT B. Terms 0 to 4 are `rdy_in[0..4]`, term 5 is the final-transfer status, and terms 6 and 7 read 0.
- R7: `ctl_out` equals the low 6 bits of the output byte of the current step of the current waveform. This includes step 7 while at rest.
- R8: When a step's opcode bit 1 is set, the step does the following:
  - In odd waveforms (1 and 3) it drives `bus_oe` high with `bus_o` equal to `wr_data` in each of its clocks.
  - In even waveforms (0 and 2) it captures `bus_i` in each of its clocks, and the value appears on `rd_data` with `rd_valid` high one clock later.
  - At rest `bus_oe` is 0.
- R9: In waveforms 2 and 3, each clock of a data step decrements the counter, which stops at 0. Waveforms 0 and 1 leave the counter unchanged. The final-transfer term is high while the counter is 1 or less, and `tc_left` shows the counter.
- R10: `abort` while busy forces step 7 on the next clock. While at rest it has no effect.
- R11: `done` is high for exactly one clock: the first clock at rest after an active step, including after an abort. `busy` is high whenever the step is not 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor byte write strobe |
| cfg_addr | input | 7 | Descriptor byte address {waveform, section, step} |
| cfg_wdata | input | 8 | Descriptor byte value |
| go | input | 1 | Start request |
| go_sel | input | 2 | Waveform to start |
| go_count | input | 16 | Transfer count loaded at start |
| abort | input | 1 | Return to rest immediately |
| rdy_in | input | 5 | External ready terms 0 to 4 |
| wr_data | input | 8 | Word driven in write data steps |
| bus_i | input | 8 | Data bus input |
| bus_o | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| rd_data | output | 8 | Last captured bus word |
| rd_valid | output | 1 | Pulse marking a new `rd_data` |
| ctl_out | output | 6 | Control line levels |
| state_out | output | 3 | Current step |
| busy | output | 1 | Engine not at rest |
| done | output | 1 | One-clock end-of-transaction pulse |
| tc_left | output | 16 | Remaining transfer count |

## Verification
A corrupted step or timer register shows on `state_out` and `ctl_out` on the very next clock. It also changes the number of clocks before `done`, so the step-by-step trace catches a wrong hold length or a wrong branch target at once.

A counter error shows as an extra or missing beat on `bus_oe` or `rd_valid` at the end of a FIFO burst. It also shows as a nonzero `tc_left` after the burst.

Read data are compared one beat later through a queue, so a dropped or duplicated capture is caught no later than the clock after the burst ends.

// File: rtl/wave_seq_pkg.sv
// Package: shared descriptor layout and ready-function codes.
// Assumes one byte per descriptor field and four fields per step.
package wave_seq_pkg;
    localparam int SEC_LENBR = 0;
    localparam int SEC_OPC   = 1;
    localparam int SEC_OUTS  = 2;
    localparam int SEC_LFN   = 3;
    localparam int NUM_SECS  = 4;

    typedef struct packed {
        logic [7:0] lfn;
        logic [7:0] outs;
        logic [7:0] opc;
        logic [7:0] lenbr;
    } step_desc_t;

    typedef enum logic [1:0] {
        FN_AND  = 2'd0,
        FN_OR   = 2'd1,
        FN_XOR  = 2'd2,
        FN_ANDN = 2'd3
    } ready_fn_e;
endpackage

// File: rtl/wave_desc_mem.sv
// Descriptor store: byte-writable array addressed {waveform, section, step}.
// Presents the four bytes of the selected waveform/step combinationally.
// Assumes NUM_WAVES and NUM_STATES are powers of two; resets to all zero.
module wave_desc_mem
    import wave_seq_pkg::*;
#(
    parameter int NUM_WAVES  = 4,
    parameter int NUM_STATES = 8,
    localparam int WAVE_W    = $clog2(NUM_WAVES),
    localparam int ST_W      = $clog2(NUM_STATES),
    localparam int ADDR_W    = WAVE_W + 2 + ST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [WAVE_W-1:0] rd_wave,
    input  logic [ST_W-1:0]   rd_step,
    output step_desc_t        rd_desc
);
    localparam int DEPTH = NUM_WAVES * NUM_SECS * NUM_STATES;

    logic [7:0] mem_q [DEPTH];

    // Store one byte per write strobe, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (cfg_we) begin
            mem_q[cfg_addr] <= cfg_wdata;
        end
    end

    // Gather the four fields of the addressed step.
    always_comb begin
        rd_desc.lenbr = mem_q[{rd_wave, 2'(SEC_LENBR), rd_step}];
        rd_desc.opc   = mem_q[{rd_wave, 2'(SEC_OPC),   rd_step}];
        rd_desc.outs  = mem_q[{rd_wave, 2'(SEC_OUTS),  rd_step}];
        rd_desc.lfn   = mem_q[{rd_wave, 2'(SEC_LFN),   rd_step}];
    end
endmodule

// File: rtl/wave_ready_logic.sv
// Ready evaluator: picks two of eight terms and combines them with the
// function coded in the top two bits of the function byte.
// Assumes external ready terms occupy indices below TC_TERM.
module wave_ready_logic
    import wave_seq_pkg::*;
#(
    parameter int EXT_RDY = 5,
    parameter int TC_TERM = 5,
    localparam int NTERM  = 8
) (
    input  logic [EXT_RDY-1:0] rdy_in,
    input  logic               tc_last,
    input  logic [7:0]         lfn,
    output logic               result
);
    logic [NTERM-1:0] terms;
    logic             term_a, term_b;
    ready_fn_e        fn;

    // Build the term vector: external pins, counter status, zeros.
    for (genvar i = 0; i < NTERM; i++) begin : g_term
        if (i < EXT_RDY) begin : g_ext
            assign terms[i] = rdy_in[i];
        end else if (i == TC_TERM) begin : g_tc
            assign terms[i] = tc_last;
        end else begin : g_zero
            assign terms[i] = 1'b0;
        end
    end

    // Select the operands and apply the chosen function.
    always_comb begin
        term_a = terms[lfn[5:3]];
        term_b = terms[lfn[2:0]];
        fn     = ready_fn_e'(lfn[7:6]);
        unique case (fn)
            FN_AND:  result = term_a & term_b;
            FN_OR:   result = term_a | term_b;
            FN_XOR:  result = term_a ^ term_b;
            default: result = term_a & ~term_b;
        endcase
    end
endmodule

// File: rtl/wave_ctrl.sv
// Step sequencer: holds the current waveform, step, hold timer and
// transfer counter, and produces the data-bus strobes and done pulse.
// Assumes the idle step is the last one and odd waveforms write,
// even ones read, and those with index bit 1 set are FIFO bursts.
module wave_ctrl
    import wave_seq_pkg::*;
#(
    parameter int NUM_WAVES  = 4,
    parameter int NUM_STATES = 8,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    localparam int WAVE_W    = $clog2(NUM_WAVES),
    localparam int ST_W      = $clog2(NUM_STATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WAVE_W-1:0] go_sel,
    input  logic [CNT_W-1:0]  go_count,
    input  logic              abort,
    input  step_desc_t        desc,
    input  logic              rdy_res,
    input  logic [DATA_W-1:0] bus_i,
    output logic [WAVE_W-1:0] wave,
    output logic [ST_W-1:0]   step,
    output logic              tc_last,
    output logic [CNT_W-1:0]  cnt,
    output logic              drive_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done
);
    localparam logic [ST_W-1:0] IDLE = ST_W'(NUM_STATES - 1);

    logic [7:0]      tmr;
    logic [ST_W-1:0] next_step;
    logic [7:0]      next_tmr;
    logic [7:0]      len_eff;
    logic            at_rest, is_dec, data_on, is_write, is_fifo, start;

    assign at_rest  = (step == IDLE);
    assign is_dec   = desc.opc[0];
    assign data_on  = !at_rest && desc.opc[1];
    assign is_write = wave[0];
    assign is_fifo  = wave[WAVE_W-1];
    assign start    = at_rest && go;
    assign len_eff  = (desc.lenbr == 8'd0) ? 8'd1 : desc.lenbr;
    assign tc_last  = (cnt <= CNT_W'(1));
    assign drive_en = data_on && is_write;

    // Choose the next step and hold-timer value.
    always_comb begin
        next_step = step;
        next_tmr  = tmr;
        if (at_rest) begin
            if (go) begin
                next_step = '0;
                next_tmr  = '0;
            end
        end else if (abort) begin
            next_step = IDLE;
            next_tmr  = '0;
        end else if (is_dec) begin
            next_step = rdy_res ? desc.lenbr[2*ST_W-1:ST_W] : desc.lenbr[ST_W-1:0];
            next_tmr  = '0;
        end else if ({1'b0, tmr} + 9'd1 >= {1'b0, len_eff}) begin
            next_step = step + ST_W'(1);
            next_tmr  = '0;
        end else begin
            next_tmr  = tmr + 8'd1;
        end
    end

    // Step, timer and selected waveform registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= IDLE;
            tmr  <= '0;
            wave <= '0;
        end else begin
            step <= next_step;
            tmr  <= next_tmr;
            if (start) wave <= go_sel;
        end
    end

    // Transfer counter: load at start, count FIFO data clocks down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= go_count;
        end else if (data_on && is_fifo && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Read capture and end-of-transaction pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            rd_valid <= data_on && !is_write;
            if (data_on && !is_write) rd_data <= bus_i;
            done     <= !at_rest && (next_step == IDLE);
        end
    end

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && step != IDLE) |=> step == IDLE);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step == IDLE) |=> (step == '0 && wave == $past(go_sel)));

    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step != IDLE) |=> $stable(wave));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> step == IDLE);

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && is_fifo && cnt != '0 && !go) |=> cnt == $past(cnt) - CNT_W'(1));

    p_rd_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(step) != IDLE);
endmodule

// File: rtl/wave_seq.sv
// Top level of the waveform sequencer: descriptor store, ready evaluator
// and step controller. The data bus is split into in/out/enable so the
// pad ring builds the tri-state driver. Control lines follow the output
// byte of the current step at all times, including the resting step.
module wave_seq
    import wave_seq_pkg::*;
#(
    parameter int NUM_WAVES  = 4,
    parameter int NUM_STATES = 8,
    parameter int DATA_W     = 8,
    parameter int CTL_W      = 6,
    parameter int CNT_W      = 16,
    parameter int EXT_RDY    = 5,
    localparam int WAVE_W    = $clog2(NUM_WAVES),
    localparam int ST_W      = $clog2(NUM_STATES),
    localparam int ADDR_W    = WAVE_W + 2 + ST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               go,
    input  logic [WAVE_W-1:0]  go_sel,
    input  logic [CNT_W-1:0]   go_count,
    input  logic               abort,
    input  logic [EXT_RDY-1:0] rdy_in,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  bus_i,
    output logic [DATA_W-1:0]  bus_o,
    output logic               bus_oe,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [CTL_W-1:0]   ctl_out,
    output logic [ST_W-1:0]    state_out,
    output logic               busy,
    output logic               done,
    output logic [CNT_W-1:0]   tc_left
);
    step_desc_t        desc;
    logic [WAVE_W-1:0] wave;
    logic [ST_W-1:0]   step;
    logic              tc_last, rdy_res, drive_en;

    wave_desc_mem #(.NUM_WAVES(NUM_WAVES), .NUM_STATES(NUM_STATES)) u_mem (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_wave(wave), .rd_step(step), .rd_desc(desc)
    );

    wave_ready_logic #(.EXT_RDY(EXT_RDY), .TC_TERM(5)) u_rdy (
        .rdy_in(rdy_in), .tc_last(tc_last), .lfn(desc.lfn), .result(rdy_res)
    );

    wave_ctrl #(.NUM_WAVES(NUM_WAVES), .NUM_STATES(NUM_STATES),
                .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .go_sel(go_sel), .go_count(go_count),
        .abort(abort), .desc(desc), .rdy_res(rdy_res), .bus_i(bus_i),
        .wave(wave), .step(step), .tc_last(tc_last), .cnt(tc_left),
        .drive_en(drive_en), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
    );

    // Pin-level outputs derived from the controller state.
    assign ctl_out   = desc.outs[CTL_W-1:0];
    assign bus_oe    = drive_en;
    assign bus_o     = wr_data;
    assign state_out = step;
    assign busy      = (step != ST_W'(NUM_STATES - 1));

    p_rest_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe);
endmodule

// File: tb/test_wave_seq.sv
// Scoreboard bench: the driver queues expected read words while it feeds
// the bus, and a monitor pops and compares them whenever rd_valid rises.
module test_wave_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        go = 1'b0;
    logic [1:0]  go_sel = '0;
    logic [15:0] go_count = '0;
    logic        abort = 1'b0;
    logic [4:0]  rdy_in = '0;
    logic [7:0]  wr_data = 8'h5A;
    logic [7:0]  bus_i = '0;
    logic [7:0]  bus_o, rd_data;
    logic        bus_oe, rd_valid, busy, done;
    logic [5:0]  ctl_out;
    logic [2:0]  state_out;
    logic [15:0] tc_left;

    int n_chk = 0;
    int n_err = 0;
    int n_pop = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    wave_seq i_wave_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .go(go), .go_sel(go_sel), .go_count(go_count),
        .abort(abort), .rdy_in(rdy_in), .wr_data(wr_data), .bus_i(bus_i),
        .bus_o(bus_o), .bus_oe(bus_oe), .rd_data(rd_data), .rd_valid(rd_valid),
        .ctl_out(ctl_out), .state_out(state_out), .busy(busy), .done(done),
        .tc_left(tc_left)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Monitor: compare each captured read word with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_pop++;
            if (exp_q.size() == 0) check("R8 unexpected read beat", 32'(rd_data), 32'hFFFF);
            else check("R8 read data", 32'(rd_data), 32'(exp_q.pop_front()));
        end
    end

    // R2: byte layout {waveform, section, step}.
    task automatic wr_desc(int w, int sec, int s, logic [7:0] v);
        cfg_we = 1'b1;
        cfg_addr = 7'(w * 32 + sec * 8 + s);
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start(int w, int c);
        go = 1'b1;
        go_sel = 2'(w);
        go_count = 16'(c);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic run_dec(string req, logic [7:0] lf, logic [4:0] rdy, int c, bit exp_true);
        wr_desc(2, 3, 0, lf);
        rdy_in = rdy;
        start(2, c);
        check({req, " decision step entered"}, 32'(state_out), 0);
        @(negedge clk);
        check({req, " branch target"}, 32'(state_out), exp_true ? 7 : 2);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R10 at rest after abort", 32'(state_out), 7);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int oe_beats;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 state", 32'(state_out), 7);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 bus_oe", 32'(bus_oe), 0);
        check("R1 ctl_out zero descriptors", 32'(ctl_out), 0);

        // Waveform 0: timed steps, lengths 3, 0(=1), then ones.
        wr_desc(0, 0, 0, 8'd3);
        wr_desc(0, 2, 0, 8'h04);
        wr_desc(0, 2, 1, 8'h02);
        for (int s = 2; s < 7; s++) begin
            wr_desc(0, 0, s, 8'd1);
            wr_desc(0, 2, s, 8'h01);
        end
        wr_desc(0, 2, 7, 8'h20);
        check("R7 rest output of waveform 0", 32'(ctl_out), 32'h20);
        start(0, 9);
        begin
            int seq[9] = '{0, 0, 0, 1, 2, 3, 4, 5, 6};
            for (int k = 0; k < 9; k++) begin
                check("R4 step sequence", 32'(state_out), 32'(seq[k]));
                if (k == 0) check("R7 ctl in step 0", 32'(ctl_out), 32'h04);
                if (k == 3) check("R7 ctl in step 1", 32'(ctl_out), 32'h02);
                @(negedge clk);
            end
        end
        check("R4 step 6 leads to rest", 32'(state_out), 7);
        check("R11 done pulse", 32'(done), 1);
        check("R9 single waveform keeps count", 32'(tc_left), 9);
        @(negedge clk);
        check("R11 done lasts one clock", 32'(done), 0);

        // R3 trigger while busy ignored; R10 abort; R11 done after abort.
        start(0, 1);
        go = 1'b1;
        go_sel = 2'd3;
        @(negedge clk);
        go = 1'b0;
        check("R3 busy trigger ignored, step", 32'(state_out), 0);
        check("R3 busy trigger ignored, ctl", 32'(ctl_out), 32'h04);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R10 abort to rest", 32'(state_out), 7);
        check("R11 done after abort", 32'(done), 1);
        check("R11 busy low at rest", 32'(busy), 0);
        @(negedge clk);

        // Waveform 1: single write with decision to rest.
        wr_desc(1, 0, 0, 8'd1);
        wr_desc(1, 1, 0, 8'h02);
        wr_desc(1, 0, 1, 8'h3F);
        wr_desc(1, 1, 1, 8'h03);
        wr_desc(1, 2, 1, 8'h01);
        wr_desc(1, 2, 7, 8'h08);
        start(1, 7);
        check("R8 write drives bus", 32'(bus_oe), 1);
        check("R8 write word", 32'(bus_o), 32'h5A);
        check("R3 started at step 0", 32'(state_out), 0);
        @(negedge clk);
        check("R7 write strobe line", 32'(ctl_out), 32'h01);
        check("R5 decision step 1", 32'(state_out), 1);
        @(negedge clk);
        check("R5 both targets rest", 32'(state_out), 7);
        check("R8 no drive at rest", 32'(bus_oe), 0);
        check("R7 rest output of waveform 1", 32'(ctl_out), 32'h08);
        check("R9 count unchanged in waveform 1", 32'(tc_left), 7);
        @(negedge clk);

        // R5/R6 decision functions on waveform 2, step 0 (true->7, false->2).
        wr_desc(2, 1, 0, 8'h01);
        wr_desc(2, 0, 0, 8'h3A);
        run_dec("R6 AND true",  8'h01, 5'b00011, 9, 1);
        run_dec("R6 AND false", 8'h01, 5'b00001, 9, 0);
        run_dec("R6 OR true",   8'h41, 5'b00001, 9, 1);
        run_dec("R6 XOR false", 8'h81, 5'b00011, 9, 0);
        run_dec("R6 ANDN true", 8'hE3, 5'b10000, 9, 1);
        run_dec("R6 ANDN false",8'hE3, 5'b11000, 9, 0);
        run_dec("R6 term 6 zero", 8'h76, 5'b11111, 9, 0);
        run_dec("R9 final term count 1", 8'h2D, 5'b00000, 1, 1);
        run_dec("R9 final term count 4", 8'h2D, 5'b00000, 4, 0);

        // Waveform 2: FIFO read burst of 3 looping on step 1.
        wr_desc(2, 1, 0, 8'h00);
        wr_desc(2, 0, 0, 8'd1);
        wr_desc(2, 3, 0, 8'h00);
        wr_desc(2, 1, 1, 8'h03);
        wr_desc(2, 0, 1, 8'h39);
        wr_desc(2, 3, 1, 8'h2D);
        n_pop = 0;
        start(2, 3);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check("R9 read burst loops", 32'(state_out), 1);
            bus_i = 8'hA0 + 8'(k);
            exp_q.push_back(bus_i);
            @(negedge clk);
        end
        check("R9 burst ends at rest", 32'(state_out), 7);
        check("R9 counter drained", 32'(tc_left), 0);
        @(negedge clk);
        check("R8 read beats", 32'(n_pop), 3);
        check("R8 queue empty", 32'(exp_q.size()), 0);

        // Waveform 3: FIFO write burst of 2.
        wr_desc(3, 0, 0, 8'd1);
        wr_desc(3, 1, 1, 8'h03);
        wr_desc(3, 0, 1, 8'h39);
        wr_desc(3, 3, 1, 8'h2D);
        wr_data = 8'hC3;
        start(3, 2);
        oe_beats = 0;
        for (int k = 0; k < 5; k++) begin
            if (bus_oe && bus_o == 8'hC3) oe_beats++;
            @(negedge clk);
        end
        check("R8 write burst beats", 32'(oe_beats), 2);
        check("R9 write counter drained", 32'(tc_left), 0);
        check("R1 back at rest", 32'(busy), 0);

        finish_run();
    end
endmodule